// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. The analog parts sit outside it: an input multiplexer, a sample/hold stage, a resistor-string tap selector and a comparator. On a start request the block latches the requested channel onto the multiplexer select and opens the sample/hold stage for a programmable number of clock cycles. It then switches the stage to hold and walks a trial code from the most significant bit down to bit 0. Each trial takes one clock cycle. The comparator answer is taken at the end of the cycle and decides whether the bit under test stays set.

After the last trial the decided code moves into a separate result register, where it stays until the next conversion completes. An end-of-conversion interrupt pulse can be raised at the same time, and the interrupt-enable input gates it. The first result after reset, or after the converter is re-enabled, is tagged with a flag so that software can discard it, because that reading may fall outside the rated accuracy. Dropping the enable aborts any conversion that is in progress.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the block is idle, with busy, hold, irq, first_flag, result, trial_code and mux_sel all at zero.
- R2: A start is accepted only when the block is idle and en is high. At acceptance chan_sel is copied to mux_sel, and mux_sel holds that value for the whole conversion even if chan_sel changes. A start while en is low starts nothing.
- R3: After an accepted start, hold is low for max(1, samp_cycles) cycles and then high for exactly 10 cycles. busy is high across both phases.
- R4: The first trial code presented while hold is high is 512, which is bit 9 set and all other bits clear.
- R5: At the end of each trial cycle, the bit under test stays 1 when cmp_in is 1 and is cleared when cmp_in is 0. The next lower bit is then set. The second trial is therefore 768 when the input is at least 512 and 256 otherwise.
- R6: When busy falls at the end of a conversion, result equals the code decided by the 10 trials. With a comparator that reports input >= trial_code, this equals the input value. result keeps this value while no further conversion completes.
- R7: irq is high for exactly the one cycle that follows the last trial, and only when irq_en was high. In that cycle busy is already low.
- R8: A start that arrives while a conversion is running is ignored. The running conversion keeps its length and its result, and no second conversion follows.
- R9: first_flag is 1 with the first result completed after reset or after en rises, and 0 with every later result.
- R10: When en goes low during a conversion, busy and hold drop at the next clock edge. result is not updated and irq is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low aborts and re-arms first-result flag |
| start | input | 1 | Conversion start request |
| chan_sel | input | 3 | Requested analog channel |
| samp_cycles | input | 8 | Sample phase length in clocks (0 treated as 1) |
| irq_en | input | 1 | End-of-conversion interrupt enable |
| cmp_in | input | 1 | Comparator: 1 when analog input >= tap |
| mux_sel | output | 3 | Analog multiplexer select |
| hold | output | 1 | Sample/hold control, 1 = hold |
| trial_code | output | 10 | Trial code to the tap selector |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Latched conversion result |
| irq | output | 1 | End-of-conversion interrupt pulse |
| first_flag | output | 1 | Current result is the first after enable |

## Verification
The conversion is exercised with the two rail codes 0 and 1023, with the pair 511 and 512 that split on the MSB decision, and with the alternating codes 341 and 682, in which every trial decision flips. Mid-scale and arbitrary values are also run. The rails show that no bit is forced or lost at either end. The 511/512 pair and the second-trial code separate a wrong MSB decision from a wrong bit-advance. The alternating patterns expose an off-by-one in the bit index. Sample lengths of 0, 1 and several cycles separate the minimum-length rule from an ordinary count. Conversions with a mid-flight restart, a channel change and an abort check that the sequence and the latched result cannot be disturbed.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CH_W     = 3,
  parameter int SAMP_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        start,
  input  logic [CH_W-1:0]             chan_sel,
  input  logic [SAMP_W-1:0]           samp_cycles,
  output logic [CH_W-1:0]             mux_sel,
  output logic                        hold,
  output logic                        busy,
  output logic                        load_msb,
  output logic                        step,
  output logic [$clog2(RES_BITS)-1:0] bit_idx
);
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

  seq_state_e          state_q, state_d;
  logic [SAMP_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [CH_W-1:0]     mux_q;
  logic [SAMP_W-1:0]   samp_last;
  logic                accept;
  logic                samp_end;

  // a zero length is stretched to one sample cycle
  assign samp_last = (samp_cycles == '0) ? '0 : samp_cycles - 1'b1;
  assign accept    = (state_q == ST_IDLE) && en && start;
  assign samp_end  = (state_q == ST_SAMPLE) && (cnt_q == samp_last);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SAMPLE;
          cnt_d   = '0;
        end
      end
      ST_SAMPLE: begin
        if (!en) begin
          state_d = ST_IDLE;
        end else if (samp_end) begin
          state_d = ST_CONVERT;
          idx_d   = TOP_IDX;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONVERT: begin
        if (!en || (idx_q == '0)) begin
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  // channel register loads only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0;
    end else if (accept) begin
      mux_q <= chan_sel;
    end
  end

  assign mux_sel  = mux_q;
  assign hold     = (state_q == ST_CONVERT);
  assign busy     = (state_q != ST_IDLE);
  assign load_msb = samp_end && en;
  assign step     = (state_q == ST_CONVERT) && en;
  assign bit_idx  = idx_q;

  // R10: disable drops the sequence at the next edge
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R8: a start inside a running trial sequence does not restart it
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONVERT && start && en && idx_q != '0) |=> (state_q == ST_CONVERT));

  // R2: multiplexer select frozen while busy
  p_chan_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mux_sel));
endmodule

// File: rtl/sar_adc_trial.sv
module sar_adc_trial #(
  parameter int RES_BITS = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_msb,
  input  logic                        step,
  input  logic                        clr,
  input  logic [$clog2(RES_BITS)-1:0] bit_idx,
  input  logic                        cmp_in,
  output logic [RES_BITS-1:0]         trial_code,
  output logic [RES_BITS-1:0]         final_code
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code_q, code_d;
  logic                code_en;

  assign code_en = load_msb || step || clr;

  always_comb begin
    code_d = code_q;
    if (load_msb) begin
      code_d = MSB_ONLY;
    end else if (step) begin
      for (int i = 0; i < RES_BITS; i++) begin
        if (int'(bit_idx) == i) begin
          code_d[i] = cmp_in;
        end else if (int'(bit_idx) == i + 1) begin
          code_d[i] = 1'b1;
        end
      end
    end else if (clr) begin
      code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign trial_code = code_q;
  assign final_code = code_d;

  // R5: comparator low clears the bit under test
  p_bit_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cmp_in) |=> !code_q[$past(bit_idx)]);

  // R5: comparator high keeps the bit under test
  p_bit_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cmp_in) |=> code_q[$past(bit_idx)]);
endmodule

// File: rtl/sar_adc_result.sv
module sar_adc_result #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                done,
  input  logic [RES_BITS-1:0] final_code,
  input  logic                irq_en,
  output logic [RES_BITS-1:0] result,
  output logic                irq,
  output logic                first_flag
);
  logic [RES_BITS-1:0] res_q;
  logic                irq_q, irq_d;
  logic                first_q;
  logic                armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!en) begin
      armed_d = 1'b1;
    end else if (done) begin
      armed_d = 1'b0;
    end
    irq_d = done && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      first_q <= 1'b0;
    end else if (done) begin
      res_q   <= final_code;
      first_q <= armed_q;
    end
  end

  assign result     = res_q;
  assign irq        = irq_q;
  assign first_flag = first_q;

  // R7: interrupt lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: interrupt only with enable set
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_BITS = 10,
  parameter int CH_W     = 3,
  parameter int SAMP_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic [SAMP_W-1:0]   samp_cycles,
  input  logic                irq_en,
  input  logic                cmp_in,
  output logic [CH_W-1:0]     mux_sel,
  output logic                hold,
  output logic [RES_BITS-1:0] trial_code,
  output logic                busy,
  output logic [RES_BITS-1:0] result,
  output logic                irq,
  output logic                first_flag
);
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic             load_msb;
  logic             step;
  logic             done;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_BITS-1:0] final_code;

  sar_adc_seq #(
    .RES_BITS (RES_BITS),
    .CH_W     (CH_W),
    .SAMP_W   (SAMP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .start       (start),
    .chan_sel    (chan_sel),
    .samp_cycles (samp_cycles),
    .mux_sel     (mux_sel),
    .hold        (hold),
    .busy        (busy),
    .load_msb    (load_msb),
    .step        (step),
    .bit_idx     (bit_idx)
  );

  sar_adc_trial #(
    .RES_BITS (RES_BITS)
  ) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_msb   (load_msb),
    .step       (step),
    .clr        (!busy),
    .bit_idx    (bit_idx),
    .cmp_in     (cmp_in),
    .trial_code (trial_code),
    .final_code (final_code)
  );

  assign done = step && (bit_idx == '0);

  sar_adc_result #(
    .RES_BITS (RES_BITS)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .done       (done),
    .final_code (final_code),
    .irq_en     (irq_en),
    .result     (result),
    .irq        (irq),
    .first_flag (first_flag)
  );

  // R4: the trial sequence opens with the MSB alone
  p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> (trial_code == MSB_ONLY));

  // R7: interrupt follows the last trial, with the block already idle
  p_irq_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(hold)));
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RES_BITS   = 10;
  localparam int CH_W       = 3;
  localparam int SAMP_W     = 8;

  typedef struct packed {
    logic [10:0] vin;
    logic [2:0]  chan;
    logic [7:0]  samp;
    logic        irq_e;
    logic        first;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, en, start, irq_en, cmp_in;
  logic [CH_W-1:0]     chan_sel, mux_sel;
  logic [SAMP_W-1:0]   samp_cycles;
  logic                hold, busy, irq, first_flag;
  logic [RES_BITS-1:0] trial_code, result;

  int   vin_model;
  int   checks = 0;
  int   fails  = 0;
  bit   abort_mode = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural comparator: input against the tap code
  assign cmp_in = (vin_model >= int'(trial_code));

  sar_adc_ctrl #(.RES_BITS(RES_BITS), .CH_W(CH_W), .SAMP_W(SAMP_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .chan_sel(chan_sel),
    .samp_cycles(samp_cycles), .irq_en(irq_en), .cmp_in(cmp_in),
    .mux_sel(mux_sel), .hold(hold), .trial_code(trial_code), .busy(busy),
    .result(result), .irq(irq), .first_flag(first_flag)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit prev_busy = 0, irq_next = 0, mux_bad = 0;
  int samp_seen = 0, conv_seen = 0, t0 = 0, t1 = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 0; samp_seen = 0; conv_seen = 0; mux_bad = 0; irq_next = 0;
    end else begin
      if (irq_next) begin
        check("R7 irq pulse ends", irq == 1'b0, irq, 0);
        irq_next = 0;
      end
      if (busy) begin
        if (!hold) samp_seen++;
        else begin
          if (conv_seen == 0) t0 = int'(trial_code);
          if (conv_seen == 1) t1 = int'(trial_code);
          conv_seen++;
        end
        if (exp_q.size() > 0 && mux_sel != exp_q[0].chan) mux_bad = 1;
      end else if (prev_busy && !abort_mode) begin
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", 1'b0, 0, 1);
        end else begin
          exp_t it;
          int   n_exp;
          it = exp_q.pop_front();
          n_exp = (it.samp == 0) ? 1 : int'(it.samp);
          check("R6 result", result == it.vin[9:0], result, it.vin);
          check("R3 sample cycles", samp_seen == n_exp, samp_seen, n_exp);
          check("R3 hold cycles", conv_seen == 10, conv_seen, 10);
          check("R4 first trial", t0 == 512, t0, 512);
          check("R5 second trial", t1 == ((it.vin >= 512) ? 768 : 256), t1,
                (it.vin >= 512) ? 768 : 256);
          check("R7 irq at end", irq == it.irq_e, irq, it.irq_e);
          check("R9 first flag", first_flag == it.first, first_flag, it.first);
          check("R2 channel held", mux_bad == 0, mux_bad, 0);
        end
        irq_next = 1;
      end
      if (!busy) begin
        samp_seen = 0; conv_seen = 0; mux_bad = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic run_conv(input int vin, input int chan, input int samp,
                          input bit ie, input bit first, input bit meddle);
    int n_eff;
    n_eff = (samp == 0) ? 1 : samp;
    @(posedge clk); #1;
    vin_model   = vin;
    chan_sel    = CH_W'(chan);
    samp_cycles = SAMP_W'(samp);
    irq_en      = ie;
    exp_q.push_back({11'(vin), 3'(chan), 8'(samp), ie, first});
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (meddle) begin
      repeat (n_eff + 3) @(posedge clk);
      #1;
      start    = 1'b1;
      chan_sel = ~CH_W'(chan);   // R8 and R2: restart and channel change mid-conversion
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (busy) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
    if (meddle) check("R8 no second conversion", busy == 1'b0, busy, 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1'b0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [RES_BITS-1:0] kept;
    rst_n = 1'b0; en = 1'b0; start = 1'b0; irq_en = 1'b0;
    chan_sel = '0; samp_cycles = '0; vin_model = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 busy", busy == 0, busy, 0);
    check("R1 hold", hold == 0, hold, 0);
    check("R1 irq", irq == 0, irq, 0);
    check("R1 result", result == 0, result, 0);
    check("R1 first_flag", first_flag == 0, first_flag, 0);
    check("R1 trial_code", trial_code == 0, trial_code, 0);
    check("R1 mux_sel", mux_sel == 0, mux_sel, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    en = 1'b1;

    run_conv(700, 3, 4, 1'b1, 1'b1, 1'b0);
    run_conv(0,    1, 0, 1'b1, 1'b0, 1'b0);
    run_conv(1023, 6, 1, 1'b0, 1'b0, 1'b0);
    run_conv(512,  2, 3, 1'b1, 1'b0, 1'b0);
    run_conv(511,  7, 2, 1'b1, 1'b0, 1'b0);
    run_conv(341,  4, 5, 1'b1, 1'b0, 1'b0);
    run_conv(682,  0, 7, 1'b0, 1'b0, 1'b0);
    run_conv(1,    5, 1, 1'b1, 1'b0, 1'b0);

    // R6: result held while idle with a changed input
    kept = result;
    vin_model = 5;
    repeat (20) @(posedge clk);
    #1;
    check("R6 result held", result == kept, result, kept);
    check("R6 no spurious irq", irq == 0, irq, 0);

    // R8 / R2: restart and channel change during conversion
    run_conv(300, 5, 2, 1'b1, 1'b0, 1'b1);

    // R10: abort by disable
    kept = result;
    abort_mode = 1;
    vin_model = 777; chan_sel = 3'd1; samp_cycles = 8'd2; irq_en = 1'b1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check("R10 converting before abort", hold == 1'b1, hold, 1);
    en = 1'b0;
    @(posedge clk); #1;
    check("R10 busy drops", busy == 0, busy, 0);
    check("R10 hold drops", hold == 0, hold, 0);
    repeat (3) @(posedge clk);
    #1;
    check("R10 result untouched", result == kept, result, kept);
    check("R10 no irq", irq == 0, irq, 0);
    // R2: start while disabled does nothing
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    check("R2 start ignored when disabled", busy == 0, busy, 0);
    abort_mode = 0;
    en = 1'b1;

    // R9: first result after re-enable is flagged again
    run_conv(900, 2, 2, 1'b1, 1'b1, 1'b0);
    run_conv(123, 3, 3, 1'b1, 1'b0, 1'b0);

    check("scoreboard drained", exp_q.size() == 0, exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule